// File: doc/BRIEF.md
# Audio Sample Fetch DMA Engine

This block fetches one period of 32-bit audio words from memory and writes them into a transmit FIFO. Software sets it up through a small byte-wide register file. It writes an inclusive byte range as two 32-bit addresses, each loaded one byte at a time. It picks a burst size and then pulses a start strobe. The engine issues word-aligned burst read commands on a simple command/data interface. Each returned word goes to the FIFO write port. When the word at the stop address has been accepted, the engine returns to idle.

Six events are collected in a status register that software clears by writing one to a bit. The events are end of period, bus error, lost sample, retry, FIFO full and FIFO empty. A mask register decides which events are recorded at all. A separate mute register decides which recorded bits may drive the interrupt line. The engine also gates its own reads: it issues no new burst while the FIFO holds too many words to accept a whole burst.

Top module: `audio_fetch_dma`

## Requirements
- R1: After reset the status register (offset 0x0D) reads 0x00, the mask register (0x0C) reads 0xFF, the mute register (0x0E) reads 0x3F, and both `irq` and `rd_cmd_valid` are low.
- R2: The start address is written least significant byte first at offsets 0x04..0x07, and the inclusive stop address at 0x08..0x0B. All eight bytes read back as written.
- R3: The configuration register (0x00) selects the burst size. Bits 2:1 give 0 = 4 words, 1 = 8 words, 2 or 3 = 16 words, and take effect only while bit 0 is set; with bit 0 clear every command is 1 word. Each burst ends at the next multiple of the burst size in word-address terms, so the first burst after an unaligned start is shortened.
- R4: A command is shortened at the end of the range so that no word past the stop address is requested. The words delivered to the FIFO are exactly those from the start address to the stop address, in order.
- R5: Writing 1 to bit 0 of offset 0x01 starts a transfer. When the word at the stop address is accepted, status bit 2 (done) is set and no further command is issued.
- R6: Writing 1 to bit 0 of offset 0x02 aborts a transfer at once. No further command is issued and done is not set.
- R7: Writing 1 to a bit of the status register clears that bit. The bit layout is 5 error, 4 lost, 3 retry, 2 done, 1 FIFO full, 0 FIFO empty.
- R8: A set bit in the mask register stops the matching event from being recorded. The mapping is mask bit 7 = done and mask bits 5, 4, 3, 1, 0 = the status bits of the same position.
- R9: `irq` is high exactly when some status bit is set whose bit in the mute register (same layout as status) is clear.
- R10: No command is presented while `fifo_level` exceeds DEPTH minus the current burst size.
- R11: FIFO full (bit 1) is recorded when `fifo_level` reaches DEPTH. FIFO empty (bit 0) is recorded when `fifo_level` falls to zero while a transfer is active.
- R12: Writing configuration bit 7 produces a one-cycle `fifo_flush` pulse, and bit 7 reads back as 0. Configuration bit 3 drives `bus_lock` while a transfer is active.
- R13: A data beat with `rd_data_err` high is not written to the FIFO. It records status bit 5 and ends the transfer. Pulses on `ev_lost` and `ev_retry` record bits 4 and 3.
- R14: The threshold register (0x03) reads back and drives `fifo_thresh`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on reg_addr) |
| rd_cmd_valid | output | 1 | Burst read command valid |
| rd_cmd_ready | input | 1 | Memory side accepts the command |
| rd_cmd_addr | output | 32 | Byte address of the first word of the burst |
| rd_cmd_words | output | 5 | Number of words in the burst (1..16) |
| rd_data_valid | input | 1 | Returned data beat valid |
| rd_data | input | 32 | Returned data word |
| rd_data_err | input | 1 | Bus error on this beat |
| fifo_wr | output | 1 | FIFO write enable |
| fifo_wdata | output | 32 | FIFO write data |
| fifo_level | input | LVL_W | Current FIFO fill level in words |
| fifo_flush | output | 1 | One-cycle FIFO reset pulse |
| fifo_thresh | output | 8 | Minimum fill level, in 32-byte units |
| bus_lock | output | 1 | Request to hold the bus during a transfer |
| ev_lost | input | 1 | Lost-sample event pulse |
| ev_retry | input | 1 | Retry event pulse |
| irq | output | 1 | Interrupt request |

## Verification
Transfers are run with each burst size from an aligned start. An unaligned start tells boundary-shortened bursts apart from plain ones. A range that is not a whole number of bursts exposes a tail that reads past the stop address. Single-word mode shows whether the burst-enable bit is honoured. A transfer stalled by a high FIFO level separates the flow-control gate from abort. The same stall lets the FIFO drain to zero mid-transfer, which is the only way to see the empty event. Mask, mute and write-one-to-clear are each toggled around a recorded done event. This tells apart an event that was never recorded from one that was recorded but kept off `irq`.

// File: rtl/afd_pkg.sv
package afd_pkg;

    localparam int BURST_W = 5;

    localparam logic [3:0] OFF_CFG    = 4'h0;
    localparam logic [3:0] OFF_GO     = 4'h1;
    localparam logic [3:0] OFF_HALT   = 4'h2;
    localparam logic [3:0] OFF_THR    = 4'h3;
    localparam logic [3:0] OFF_SA0    = 4'h4;
    localparam logic [3:0] OFF_EA0    = 4'h8;
    localparam logic [3:0] OFF_MASK   = 4'hC;
    localparam logic [3:0] OFF_STAT   = 4'hD;
    localparam logic [3:0] OFF_MUTE   = 4'hE;

    localparam int EV_EMPTY = 0;
    localparam int EV_FULL  = 1;
    localparam int EV_DONE  = 2;
    localparam int EV_RETRY = 3;
    localparam int EV_LOST  = 4;
    localparam int EV_ERR   = 5;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_ISSUE = 2'd1,
        SQ_DATA  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic       flush;
        logic [2:0] rsvd;
        logic       lock;
        logic [1:0] size_sel;
        logic       burst_on;
    } cfg_t;

    function automatic logic [BURST_W-1:0] burst_words(input cfg_t c);
        if (!c.burst_on)          return 5'd1;
        else if (c.size_sel == 0) return 5'd4;
        else if (c.size_sel == 1) return 5'd8;
        else                      return 5'd16;
    endfunction

endpackage

// File: rtl/audio_fetch_regs.sv
module audio_fetch_regs
    import afd_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr,
    input  logic [3:0]  addr,
    input  logic [7:0]  wdata,
    input  logic [5:0]  status,
    output logic [7:0]  rdata,
    output cfg_t        cfg,
    output logic        go_pulse,
    output logic        halt_pulse,
    output logic        flush_pulse,
    output logic [7:0]  thresh,
    output logic [31:0] start_addr,
    output logic [31:0] stop_addr,
    output logic [7:0]  mask,
    output logic [5:0]  mute,
    output logic [5:0]  clr_bits
);

    logic [7:0] cfg_q;

    assign cfg        = cfg_t'(cfg_q);
    assign go_pulse   = wr && addr == OFF_GO   && wdata[0];
    assign halt_pulse = wr && addr == OFF_HALT && wdata[0];
    assign clr_bits   = (wr && addr == OFF_STAT) ? wdata[5:0] : 6'd0;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q       <= 8'h00;
            thresh      <= 8'h00;
            start_addr  <= 32'd0;
            stop_addr   <= 32'd0;
            mask        <= 8'hFF;
            mute        <= 6'h3F;
            flush_pulse <= 1'b0;
        end else begin
            flush_pulse <= wr && addr == OFF_CFG && wdata[7];
            if (wr) begin
                case (addr)
                    OFF_CFG:  cfg_q  <= {1'b0, wdata[6:0]};
                    OFF_THR:  thresh <= wdata;
                    OFF_MASK: mask   <= wdata;
                    OFF_MUTE: mute   <= wdata[5:0];
                    default: begin
                        if (addr[3:2] == OFF_SA0[3:2])
                            start_addr[addr[1:0]*8 +: 8] <= wdata;
                        else if (addr[3:2] == OFF_EA0[3:2])
                            stop_addr[addr[1:0]*8 +: 8] <= wdata;
                    end
                endcase
            end
        end
    end

    always_comb begin
        case (addr)
            OFF_CFG:  rdata = cfg_q;
            OFF_THR:  rdata = thresh;
            OFF_MASK: rdata = mask;
            OFF_STAT: rdata = {2'b00, status};
            OFF_MUTE: rdata = {2'b00, mute};
            default: begin
                if (addr[3:2] == OFF_SA0[3:2])
                    rdata = start_addr[addr[1:0]*8 +: 8];
                else if (addr[3:2] == OFF_EA0[3:2])
                    rdata = stop_addr[addr[1:0]*8 +: 8];
                else
                    rdata = 8'h00;
            end
        endcase
    end

endmodule

// File: rtl/audio_fetch_seq.sv
module audio_fetch_seq
    import afd_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               go,
    input  logic               halt,
    input  logic [31:0]        start_addr,
    input  logic [31:0]        stop_addr,
    input  logic [BURST_W-1:0] bw,
    input  logic [LVL_W-1:0]   fifo_level,
    output logic               cmd_valid,
    input  logic               cmd_ready,
    output logic [31:0]        cmd_addr,
    output logic [BURST_W-1:0] cmd_words,
    input  logic               rd_valid,
    input  logic               rd_err,
    output logic               push,
    output logic               active,
    output logic               done_ev,
    output logic               err_ev
);

    seq_state_e         st;
    logic [29:0]        cur_w;
    logic [29:0]        end_w;
    logic [BURST_W-1:0] left;
    logic [30:0]        remain;
    logic [BURST_W-1:0] to_bnd;
    logic               room;
    logic               last_word;

    assign remain    = {1'b0, end_w} - {1'b0, cur_w} + 31'd1;
    assign to_bnd    = bw - (cur_w[BURST_W-1:0] & (bw - 5'd1));
    assign cmd_words = (remain < {26'd0, to_bnd}) ? remain[BURST_W-1:0] : to_bnd;
    assign cmd_addr  = {cur_w, 2'b00};
    assign room      = (int'(fifo_level) + int'(bw)) <= DEPTH;
    assign cmd_valid = st == SQ_ISSUE && room;
    assign push      = st == SQ_DATA && rd_valid && !rd_err;
    assign err_ev    = st == SQ_DATA && rd_valid && rd_err;
    assign last_word = cur_w == end_w;
    assign done_ev   = push && last_word;
    assign active    = st != SQ_IDLE;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= SQ_IDLE;
            cur_w <= '0;
            end_w <= '0;
            left  <= '0;
        end else if (halt) begin
            st <= SQ_IDLE;
        end else begin
            case (st)
                SQ_IDLE: if (go) begin
                    cur_w <= start_addr[31:2];
                    end_w <= stop_addr[31:2];
                    st    <= SQ_ISSUE;
                end
                SQ_ISSUE: if (cmd_valid && cmd_ready) begin
                    left <= cmd_words;
                    st   <= SQ_DATA;
                end
                SQ_DATA: if (rd_valid) begin
                    if (rd_err) begin
                        st <= SQ_IDLE;
                    end else begin
                        cur_w <= cur_w + 30'd1;
                        left  <= left - 5'd1;
                        if (last_word)      st <= SQ_IDLE;
                        else if (left == 1) st <= SQ_ISSUE;
                    end
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/audio_fetch_evt.sv
module audio_fetch_evt
    import afd_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic             active,
    input  logic             done_ev,
    input  logic             err_ev,
    input  logic             lost_ev,
    input  logic             retry_ev,
    input  logic [7:0]       mask,
    input  logic [5:0]       mute,
    input  logic [5:0]       clr_bits,
    output logic [5:0]       status,
    output logic             irq
);

    logic [LVL_W-1:0] lvl_q;
    logic [5:0]       raw;
    logic [5:0]       blocked;

    always_comb begin
        raw            = '0;
        raw[EV_EMPTY]  = active && fifo_level == '0 && lvl_q != '0;
        raw[EV_FULL]   = int'(fifo_level) == DEPTH && int'(lvl_q) != DEPTH;
        raw[EV_DONE]   = done_ev;
        raw[EV_RETRY]  = retry_ev;
        raw[EV_LOST]   = lost_ev;
        raw[EV_ERR]    = err_ev;
        blocked        = {mask[5:3], mask[7], mask[1:0]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q  <= '0;
            status <= '0;
        end else begin
            lvl_q  <= fifo_level;
            status <= (status & ~clr_bits) | (raw & ~blocked);
        end
    end

    assign irq = |(status & ~mute);

endmodule

// File: rtl/audio_fetch_dma.sv
module audio_fetch_dma
    import afd_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic [3:0]         reg_addr,
    input  logic [7:0]         reg_wdata,
    output logic [7:0]         reg_rdata,
    output logic               rd_cmd_valid,
    input  logic               rd_cmd_ready,
    output logic [31:0]        rd_cmd_addr,
    output logic [BURST_W-1:0] rd_cmd_words,
    input  logic               rd_data_valid,
    input  logic [31:0]        rd_data,
    input  logic               rd_data_err,
    output logic               fifo_wr,
    output logic [31:0]        fifo_wdata,
    input  logic [LVL_W-1:0]   fifo_level,
    output logic               fifo_flush,
    output logic [7:0]         fifo_thresh,
    output logic               bus_lock,
    input  logic               ev_lost,
    input  logic               ev_retry,
    output logic               irq
);

    cfg_t               cfg;
    logic               go, halt, active, done_ev, err_ev;
    logic [31:0]        start_addr, stop_addr;
    logic [7:0]         mask;
    logic [5:0]         mute, clr_bits, status;
    logic [BURST_W-1:0] bw;

    assign bw         = burst_words(cfg);
    assign bus_lock   = cfg.lock && active;
    assign fifo_wdata = rd_data;

    audio_fetch_regs u_regs (
        .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .status(status), .rdata(reg_rdata), .cfg(cfg), .go_pulse(go),
        .halt_pulse(halt), .flush_pulse(fifo_flush), .thresh(fifo_thresh),
        .start_addr(start_addr), .stop_addr(stop_addr), .mask(mask),
        .mute(mute), .clr_bits(clr_bits)
    );

    audio_fetch_seq #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_seq (
        .clk(clk), .rst(rst), .go(go), .halt(halt), .start_addr(start_addr),
        .stop_addr(stop_addr), .bw(bw), .fifo_level(fifo_level),
        .cmd_valid(rd_cmd_valid), .cmd_ready(rd_cmd_ready),
        .cmd_addr(rd_cmd_addr), .cmd_words(rd_cmd_words),
        .rd_valid(rd_data_valid), .rd_err(rd_data_err), .push(fifo_wr),
        .active(active), .done_ev(done_ev), .err_ev(err_ev)
    );

    audio_fetch_evt #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_evt (
        .clk(clk), .rst(rst), .fifo_level(fifo_level), .active(active),
        .done_ev(done_ev), .err_ev(err_ev), .lost_ev(ev_lost),
        .retry_ev(ev_retry), .mask(mask), .mute(mute), .clr_bits(clr_bits),
        .status(status), .irq(irq)
    );

endmodule

// File: rtl/audio_fetch_chk.sv
module audio_fetch_chk
    import afd_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input logic               clk,
    input logic               rst,
    input logic               reg_wr,
    input logic [3:0]         reg_addr,
    input logic [7:0]         reg_wdata,
    input logic               rd_cmd_valid,
    input logic [31:0]        rd_cmd_addr,
    input logic [BURST_W-1:0] rd_cmd_words,
    input logic               rd_data_valid,
    input logic               rd_data_err,
    input logic               fifo_wr,
    input logic               fifo_flush,
    input logic [LVL_W-1:0]   fifo_level,
    input logic [31:0]        stop_addr,
    input cfg_t               cfg
);

    // R4: a command never reaches past the inclusive stop word
    a_r4_no_overrun: assert property (@(posedge clk) disable iff (rst)
        rd_cmd_valid |-> ({2'b00, rd_cmd_addr[31:2]} + 32'(rd_cmd_words) - 32'd1)
                         <= {2'b00, stop_addr[31:2]});

    // R3: burst length is between one word and the configured size
    a_r3_burst_bounded: assert property (@(posedge clk) disable iff (rst)
        rd_cmd_valid |-> (rd_cmd_words != 0 && rd_cmd_words <= burst_words(cfg)));

    // R10: no command while the FIFO lacks room for a whole burst
    a_r10_room: assert property (@(posedge clk) disable iff (rst)
        rd_cmd_valid |-> (int'(fifo_level) + int'(burst_words(cfg)) <= DEPTH));

    // R12: flush is a single-cycle pulse
    a_r12_flush_pulse: assert property (@(posedge clk) disable iff (rst)
        fifo_flush |=> !fifo_flush);

    // R6: a stop strobe silences the command port on the next cycle
    a_r6_halt_quiet: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == OFF_HALT && reg_wdata[0]) |=> !rd_cmd_valid);

    // R13: an errored beat is never written to the FIFO
    a_r13_err_nowrite: assert property (@(posedge clk) disable iff (rst)
        (rd_data_valid && rd_data_err) |-> !fifo_wr);

endmodule

bind audio_fetch_dma audio_fetch_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .rd_cmd_valid(rd_cmd_valid),
    .rd_cmd_addr(rd_cmd_addr), .rd_cmd_words(rd_cmd_words),
    .rd_data_valid(rd_data_valid), .rd_data_err(rd_data_err),
    .fifo_wr(fifo_wr), .fifo_flush(fifo_flush), .fifo_level(fifo_level),
    .stop_addr(stop_addr), .cfg(cfg)
);

// File: tb/audio_fetch_dma_bench.sv
`timescale 1ns/1ps
module audio_fetch_dma_bench;

    localparam int DEPTH = 64;
    localparam int LVL_W = $clog2(DEPTH + 1);
    localparam logic [31:0] KEY = 32'h5A00_0000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic reg_wr = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic rd_cmd_valid;
    logic rd_cmd_ready = 1'b1;
    logic [31:0] rd_cmd_addr;
    logic [4:0] rd_cmd_words;
    logic rd_data_valid = 1'b0;
    logic [31:0] rd_data = '0;
    logic rd_data_err = 1'b0;
    logic fifo_wr;
    logic [31:0] fifo_wdata;
    logic [LVL_W-1:0] fifo_level = '0;
    logic fifo_flush;
    logic [7:0] fifo_thresh;
    logic bus_lock;
    logic ev_lost = 1'b0;
    logic ev_retry = 1'b0;
    logic irq;

    always #5 clk = ~clk;

    audio_fetch_dma #(.DEPTH(DEPTH)) u_audio_fetch_dma (.*);

    int checks = 0;
    int errors = 0;

    logic [63:0] exp_cmd[$];
    logic [31:0] exp_dat[$];
    int          beats = 0;
    logic [31:0] raddr = '0;
    int          pend_n = 0;
    logic [31:0] pend_a = '0;
    logic        err_arm = 1'b0;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: commands accepted at the next edge
    always @(negedge clk) begin
        if (!rst && rd_cmd_valid && rd_cmd_ready) begin
            if (exp_cmd.size() == 0) begin
                check(1'b0, "R6 unexpected command", {rd_cmd_addr, 27'd0, rd_cmd_words}, 64'd0);
            end else begin
                logic [63:0] e;
                e = exp_cmd.pop_front();
                check({rd_cmd_addr, 27'd0, rd_cmd_words} == e, "R3/R4 burst command",
                      {rd_cmd_addr, 27'd0, rd_cmd_words}, e);
            end
            pend_n = int'(rd_cmd_words);
            pend_a = rd_cmd_addr;
        end
        if (!rst && fifo_wr) begin
            if (exp_dat.size() == 0) begin
                check(1'b0, "R4 unexpected fifo word", {32'd0, fifo_wdata}, 64'd0);
            end else begin
                logic [31:0] d;
                d = exp_dat.pop_front();
                check(fifo_wdata == d, "R4 fifo word", {32'd0, fifo_wdata}, {32'd0, d});
            end
        end
    end

    // Memory responder
    always @(posedge clk) begin
        #1;
        if (beats == 0 && pend_n != 0) begin
            beats = pend_n;
            raddr = pend_a;
            pend_n = 0;
        end
        if (beats != 0) begin
            rd_data_valid = 1'b1;
            rd_data = raddr ^ KEY;
            rd_data_err = err_arm;
            if (err_arm) begin
                err_arm = 1'b0;
                beats = 0;
            end else begin
                beats--;
                raddr += 4;
            end
        end else begin
            rd_data_valid = 1'b0;
            rd_data_err = 1'b0;
        end
    end

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        reg_addr = a;
        @(negedge clk);
        d = reg_rdata;
        @(posedge clk); #1;
    endtask

    task automatic expect_reg(input logic [3:0] a, input logic [7:0] e, input string tag);
        logic [7:0] d;
        rd(a, d);
        check(d == e, tag, {56'd0, d}, {56'd0, e});
    endtask

    task automatic set_range(input logic [31:0] s, input logic [31:0] e);
        for (int i = 0; i < 4; i++) wr(4'h4 + 4'(i), s[i*8 +: 8]);
        for (int i = 0; i < 4; i++) wr(4'h8 + 4'(i), e[i*8 +: 8]);
    endtask

    // Driver: push the bursts and words the requirements predict
    task automatic plan_xfer(input logic [31:0] s, input logic [31:0] e, input int bw);
        longint cur, last, len, tob;
        cur = longint'(s >> 2);
        last = longint'(e >> 2);
        while (cur <= last) begin
            tob = bw - (cur % bw);
            len = (last - cur + 1 < tob) ? last - cur + 1 : tob;
            exp_cmd.push_back({cur[29:0], 2'b00, 27'd0, len[4:0]});
            for (longint k = 0; k < len; k++) exp_dat.push_back({cur[29:0] + k[29:0], 2'b00} ^ KEY);
            cur += len;
        end
    endtask

    task automatic wait_drain();
        while (exp_cmd.size() != 0 || exp_dat.size() != 0 || beats != 0 || pend_n != 0)
            @(posedge clk);
        repeat (4) @(posedge clk);
        #1;
    endtask

    task automatic run(input logic [31:0] s, input logic [31:0] e, input logic [7:0] cfgv, input int bw);
        wr(4'h0, cfgv);
        set_range(s, e);
        plan_xfer(s, e, bw);
        wr(4'h1, 8'h01);
        wait_drain();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", 64'd0, 64'd1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(posedge clk); #1;

        // R1 reset state
        expect_reg(4'hD, 8'h00, "R1 status reset");
        expect_reg(4'hC, 8'hFF, "R1 mask reset");
        expect_reg(4'hE, 8'h3F, "R1 mute reset");
        check(!irq && !rd_cmd_valid, "R1 irq/cmd low", {62'd0, irq, rd_cmd_valid}, 64'd0);

        // R2 address bytes
        set_range(32'h1234_5678, 32'h9ABC_DEF0);
        expect_reg(4'h4, 8'h78, "R2 start byte0");
        expect_reg(4'h7, 8'h12, "R2 start byte3");
        expect_reg(4'h8, 8'hF0, "R2 stop byte0");
        expect_reg(4'hB, 8'h9A, "R2 stop byte3");

        // R14 threshold
        wr(4'h3, 8'h7E);
        expect_reg(4'h3, 8'h7E, "R14 threshold readback");
        check(fifo_thresh == 8'h7E, "R14 fifo_thresh", {56'd0, fifo_thresh}, 64'h7E);

        // R3/R8: 4-word bursts, aligned, done masked by default
        run(32'h0000_1000, 32'h0000_103F, 8'h01, 4);
        expect_reg(4'hD, 8'h00, "R8 done masked");

        // unmask all events
        wr(4'hC, 8'h00);

        // R3/R5: 8-word bursts from an unaligned start, short tail
        run(32'h0000_2010, 32'h0000_2043, 8'h03, 8);
        expect_reg(4'hD, 8'h04, "R5 done recorded");
        check(!rd_cmd_valid, "R5 idle after done", {63'd0, rd_cmd_valid}, 64'd0);

        // R9: mute hides, unmute raises irq, R7 clears
        check(!irq, "R9 muted irq", {63'd0, irq}, 64'd0);
        wr(4'hE, 8'h3B);
        check(irq, "R9 unmuted irq", {63'd0, irq}, 64'd1);
        wr(4'hD, 8'h04);
        expect_reg(4'hD, 8'h00, "R7 write-one clear");
        check(!irq, "R9 irq after clear", {63'd0, irq}, 64'd0);

        // R4: 16-word bursts, range not a whole number of bursts
        run(32'h0000_3000, 32'h0000_304F, 8'h05, 16);
        // R3: burst mode off gives single words
        run(32'h0000_4004, 32'h0000_400F, 8'h04, 1);
        wr(4'hD, 8'h3F);

        // R10/R11/R12: stalled transfer, lock, then drain to empty
        wr(4'h0, 8'h09);
        fifo_level = LVL_W'(DEPTH - 2);
        set_range(32'h0000_5000, 32'h0000_501F);
        plan_xfer(32'h0000_5000, 32'h0000_501F, 4);
        wr(4'h1, 8'h01);
        repeat (10) @(posedge clk);
        #1;
        check(exp_cmd.size() == 2, "R10 no command while FIFO too full", 64'(exp_cmd.size()), 64'd2);
        check(bus_lock, "R12 bus_lock active", {63'd0, bus_lock}, 64'd1);
        fifo_level = '0;
        wait_drain();
        expect_reg(4'hD, 8'h05, "R11 empty and done");
        check(!bus_lock, "R12 bus_lock idle", {63'd0, bus_lock}, 64'd0);
        wr(4'hD, 8'h05);

        // R11 full
        fifo_level = LVL_W'(DEPTH);
        @(posedge clk); #1;
        fifo_level = '0;
        @(posedge clk); #1;
        expect_reg(4'hD, 8'h02, "R11 full recorded");
        wr(4'hD, 8'h02);

        // R6 abort
        fifo_level = LVL_W'(DEPTH - 2);
        set_range(32'h0000_6000, 32'h0000_603F);
        wr(4'h1, 8'h01);
        repeat (4) @(posedge clk);
        #1;
        wr(4'h2, 8'h01);
        fifo_level = '0;
        repeat (20) @(posedge clk);
        #1;
        expect_reg(4'hD, 8'h00, "R6 no done after abort");

        // R13 bus error
        set_range(32'h0000_7000, 32'h0000_703F);
        exp_cmd.push_back({32'h0000_7000, 27'd0, 5'd4});
        err_arm = 1'b1;
        wr(4'h1, 8'h01);
        repeat (12) @(posedge clk);
        #1;
        check(exp_cmd.size() == 0 && exp_dat.size() == 0, "R13 transfer ended", 64'(exp_cmd.size()), 64'd0);
        expect_reg(4'hD, 8'h20, "R13 error recorded");
        wr(4'hD, 8'h20);

        // R13 lost/retry inputs, R8 masking of them
        ev_lost = 1'b1; ev_retry = 1'b1;
        @(posedge clk); #1;
        ev_lost = 1'b0; ev_retry = 1'b0;
        expect_reg(4'hD, 8'h18, "R13 lost/retry");
        wr(4'hD, 8'h18);
        wr(4'hC, 8'h10);
        ev_lost = 1'b1;
        @(posedge clk); #1;
        ev_lost = 1'b0;
        expect_reg(4'hD, 8'h00, "R8 lost masked");

        // R12 flush pulse
        wr(4'h0, 8'h81);
        @(negedge clk);
        check(fifo_flush, "R12 flush pulse", {63'd0, fifo_flush}, 64'd1);
        @(negedge clk);
        check(!fifo_flush, "R12 flush one cycle", {63'd0, fifo_flush}, 64'd0);
        @(posedge clk); #1;
        expect_reg(4'h0, 8'h01, "R12 flush bit reads 0");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule